// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared memory that has two independent access ports, called left and right. Each cycle it looks at both ports' enables and addresses. When both ports are enabled on the same address it decides which port keeps the location. The other port sees its active-low busy flag pulled low, and that port's write strobe is suppressed before it reaches the array. The decision uses only the address and the enable. Whether an access reads or writes plays no part in it.

A mode select chooses between master and slave behaviour. In master mode the block arbitrates and drives both busy outputs. In slave mode it does no arbitration. The two busy inputs, which come from a master elsewhere, then act only as per-port write inhibits, so several slices of a wider memory obey one decision. The compared address width is a parameter. When a shallower memory uses fewer bits, the upper address bits are ignored.

The block works in clock cycles. The request history of each port is registered. The busy flags and write gates are combinational from the current inputs and the registered owner, so they act in the same cycle a collision appears.

Top module: `dpc_arb_top`

## Requirements
- R1: In master mode, if either enable is low or the compared address bits differ, both busy outputs are high in that cycle.
- R2: When one port's request (enable plus compared address) was unchanged from the previous cycle and the other port's request just changed to collide with it, the unchanged port wins. Only the newcomer's busy output goes low.
- R3: When both requests change in the same cycle and collide, or a collision exists with no recorded owner, the left port wins and right busy goes low. The two busy outputs are never low together.
- R4: The write/read input of either port has no effect on which port wins.
- R5: In master mode, a losing port's write strobe output is low whatever level is on that port's busy input. The winner's write strobe output equals enable AND write.
- R6: In slave mode both busy outputs stay high. Each port's write strobe output equals enable AND write AND that port's busy input, which is active low.
- R7: Only the low CMP_W address bits are compared. With CMP_W=12 and ADDR_W=13, addresses differing only in bit 12 collide. With CMP_W=13 they do not.
- R8: While a collision persists from one cycle to the next in master mode, the owner does not change. This holds even if both addresses move together to a new matching value.
- R9: Busy returns high in the first cycle the collision is gone. A blocked write is not reissued: afterwards the write strobe output follows only the current write input.
- R10: After reset both busy outputs are high. No port counts as settled, so the first collision after reset is treated as simultaneous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = arbitrate (master), 0 = busy pins act as inhibit inputs (slave) |
| l_ce_i | input | 1 | Left port enable, active high |
| l_we_i | input | 1 | Left port write request |
| l_addr_i | input | ADDR_W | Left port address |
| r_ce_i | input | 1 | Right port enable, active high |
| r_we_i | input | 1 | Right port write request |
| r_addr_i | input | ADDR_W | Right port address |
| l_busy_ni | input | 1 | Left write inhibit from an external master, active low, used in slave mode |
| r_busy_ni | input | 1 | Right write inhibit from an external master, active low, used in slave mode |
| l_busy_no | output | 1 | Left busy flag, active low, driven in master mode |
| r_busy_no | output | 1 | Right busy flag, active low, driven in master mode |
| l_we_o | output | 1 | Gated left write strobe toward the array |
| r_we_o | output | 1 | Gated right write strobe toward the array |

## Verification
The internal state of this block is small: one owner value and a registered request signature per port. A corrupted owner shows at once as a busy flag on the wrong side, or as a flag that flips while a collision continues. A stale signature is harder to see. It shows only at the next new collision, where the arbiter picks the wrong winner or falls back to the left-port tie rule when one side had in fact settled earlier. For that reason the stimulus builds many collisions from both a quiet and an already-enabled port, from both sides. A second instance with a narrower compare width exposes errors in the address mask.

// File: rtl/dpc_arb_pkg.sv
package dpc_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpc_addr_match.sv
module dpc_addr_match #(
  parameter int ADDR_W = 13,
  parameter int CMP_W  = 13
) (
  input  logic              a_en_i,
  input  logic              b_en_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  output logic              hit_o
);
  logic same;

  generate
    if (CMP_W < ADDR_W) begin : g_trim
      logic unused_hi;
      assign unused_hi = ^{a_addr_i[ADDR_W-1:CMP_W], b_addr_i[ADDR_W-1:CMP_W]};
      assign same = (a_addr_i[CMP_W-1:0] == b_addr_i[CMP_W-1:0]);
    end else begin : g_full
      assign same = (a_addr_i == b_addr_i);
    end
  endgenerate

  assign hit_o = a_en_i && b_en_i && same;
endmodule

// File: rtl/dpc_req_hist.sv
module dpc_req_hist #(
  parameter int ADDR_W = 13,
  parameter int CMP_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              moved_o
);
  localparam int SIG_W = CMP_W + 1;

  logic [SIG_W-1:0] sig_d, sig_q;
  logic             unused_addr;

  // a disabled port has a single signature regardless of address
  assign sig_d = en_i ? {1'b1, addr_i[CMP_W-1:0]} : '0;
  assign unused_addr = ^addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_d;
  end

  assign moved_o = (sig_d != sig_q);
endmodule

// File: rtl/dpc_arb_core.sv
module dpc_arb_core
  import dpc_arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   master_i,
  input  logic   hit_i,
  input  logic   l_moved_i,
  input  logic   r_moved_i,
  output owner_e owner_o
);
  owner_e owner_q;

  always_comb begin
    owner_o = OWN_NONE;
    if (master_i && hit_i) begin
      if (owner_q != OWN_NONE)           owner_o = owner_q;
      else if (r_moved_i && !l_moved_i)  owner_o = OWN_LEFT;   // left settled first
      else if (l_moved_i && !r_moved_i)  owner_o = OWN_RIGHT;  // right settled first
      else                               owner_o = OWN_LEFT;   // tie rule
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_o;
  end

  assert_owner_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && hit_i && owner_q != OWN_NONE) |-> (owner_o == owner_q));

  assert_owner_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> (owner_q == OWN_NONE));
endmodule

// File: rtl/dpc_arb_top.sv
module dpc_arb_top
  import dpc_arb_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int CMP_W  = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_ce_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_ce_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              l_busy_ni,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_we_o,
  output logic              r_we_o
);
  localparam int NPORT = 2;

  logic              hit;
  owner_e            owner;
  logic [NPORT-1:0]  ce, we, busy_in, moved, lose, inhibit, busy_out, we_out;
  logic [ADDR_W-1:0] addr [NPORT];

  assign ce      = {r_ce_i, l_ce_i};
  assign we      = {r_we_i, l_we_i};
  assign busy_in = {r_busy_ni, l_busy_ni};
  assign addr[0] = l_addr_i;
  assign addr[1] = r_addr_i;

  dpc_addr_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
    .a_en_i  (l_ce_i),
    .b_en_i  (r_ce_i),
    .a_addr_i(l_addr_i),
    .b_addr_i(r_addr_i),
    .hit_o   (hit)
  );

  assign lose[0] = master_i && (owner == OWN_RIGHT);
  assign lose[1] = master_i && (owner == OWN_LEFT);

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_port
      dpc_req_hist #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_hist (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (ce[g]),
        .addr_i (addr[g]),
        .moved_o(moved[g])
      );
      // master: own decision only; slave: external flag only
      assign inhibit[g]  = master_i ? lose[g] : !busy_in[g];
      assign busy_out[g] = !lose[g];
      assign we_out[g]   = ce[g] && we[g] && !inhibit[g];
    end
  endgenerate

  dpc_arb_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_i),
    .hit_i    (hit),
    .l_moved_i(moved[0]),
    .r_moved_i(moved[1]),
    .owner_o  (owner)
  );

  assign l_busy_no = busy_out[0];
  assign r_busy_no = busy_out[1];
  assign l_we_o    = we_out[0];
  assign r_we_o    = we_out[1];

  assert_idle_free_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !hit) |-> (l_busy_no && r_busy_no));

  assert_one_loser_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_busy_no || r_busy_no));

  assert_loser_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && (!l_busy_no || !r_busy_no)) |->
      ((l_busy_no || !l_we_o) && (r_busy_no || !r_we_o)));

  assert_slave_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no));

  assert_slave_inhibit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> ((l_busy_ni || !l_we_o) && (r_busy_ni || !r_we_o)));
endmodule

// File: tb/tb_dpc_arb_top.sv
module tb_dpc_arb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        master = 1'b1;
  logic        l_ce = 1'b0, l_we = 1'b0, r_ce = 1'b0, r_we = 1'b0;
  logic [12:0] l_addr = '0, r_addr = '0;
  logic        l_bi = 1'b1, r_bi = 1'b1;
  logic [3:0]  act [2];
  logic        lb0, rb0, lw0, rw0, lb1, rb1, lw1, rw1;

  int checks = 0, fails = 0;
  int m_own [2];
  logic [13:0] m_pl [2], m_pr [2];

  always #4 clk = ~clk;

  dpc_arb_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master),
    .l_ce_i(l_ce), .l_we_i(l_we), .l_addr_i(l_addr),
    .r_ce_i(r_ce), .r_we_i(r_we), .r_addr_i(r_addr),
    .l_busy_ni(l_bi), .r_busy_ni(r_bi),
    .l_busy_no(lb0), .r_busy_no(rb0), .l_we_o(lw0), .r_we_o(rw0));

  dpc_arb_top #(.ADDR_W(13), .CMP_W(12)) dut_4k (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master),
    .l_ce_i(l_ce), .l_we_i(l_we), .l_addr_i(l_addr),
    .r_ce_i(r_ce), .r_we_i(r_we), .r_addr_i(r_addr),
    .l_busy_ni(l_bi), .r_busy_ni(r_bi),
    .l_busy_no(lb1), .r_busy_no(rb1), .l_we_o(lw1), .r_we_o(rw1));

  assign act[0] = {lb0, rb0, lw0, rw0};
  assign act[1] = {lb1, rb1, lw1, rw1};

  function automatic logic [13:0] sig(input logic ce, input logic [12:0] a, input int cw);
    logic [12:0] m;
    m = (cw == 13) ? a : {1'b0, a[11:0]};
    return ce ? {1'b1, m} : 14'd0;
  endfunction

  // owner coding in the model: 0 none, 1 left wins, 2 right wins
  task automatic step(input string tag);
    int nxt [2];
    logic [13:0] cl [2], cr [2];
    #2;
    for (int d = 0; d < 2; d++) begin
      int cw;
      logic hit, lmov, rmov;
      logic [3:0] exp;
      int on;
      cw = (d == 0) ? 13 : 12;
      cl[d] = sig(l_ce, l_addr, cw);
      cr[d] = sig(r_ce, r_addr, cw);
      hit  = l_ce && r_ce && (cl[d] == cr[d]);
      lmov = (cl[d] != m_pl[d]);
      rmov = (cr[d] != m_pr[d]);
      on = 0;
      if (master && hit) begin
        if (m_own[d] != 0)      on = m_own[d];
        else if (rmov && !lmov) on = 1;
        else if (lmov && !rmov) on = 2;
        else                    on = 1;
      end
      nxt[d] = on;
      exp[3] = !(master && on == 2);
      exp[2] = !(master && on == 1);
      exp[1] = l_ce && l_we && (master ? (on != 2) : l_bi);
      exp[0] = r_ce && r_we && (master ? (on != 1) : r_bi);
      checks++;
      if (act[d] !== exp) begin
        fails++;
        $display("FAIL %s dut%0d {lbusy,rbusy,lwe,rwe} actual %b expected %b", tag, d, act[d], exp);
      end
    end
    @(posedge clk);
    #1;
    for (int d = 0; d < 2; d++) begin
      m_own[d] = nxt[d];
      m_pl[d]  = cl[d];
      m_pr[d]  = cr[d];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    master = 1'b1; l_ce = 1'b0; r_ce = 1'b0; l_we = 1'b0; r_we = 1'b0;
    l_bi = 1'b1; r_bi = 1'b1; l_addr = '0; r_addr = '0;
    step("R1");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int d = 0; d < 2; d++) begin
      m_own[d] = 0; m_pl[d] = '0; m_pr[d] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state, busy flags released
    checks++;
    if ({lb0, rb0, lb1, rb1} !== 4'b1111) begin
      fails++;
      $display("FAIL R10 busy in reset actual %b expected 1111", {lb0, rb0, lb1, rb1});
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R10: first collision after reset is a tie -> left wins
    l_ce = 1; r_ce = 1; l_addr = 13'd7; r_addr = 13'd7; r_we = 1;
    step("R10");
    idle();

    // R2: left settles first, right arrives later
    l_ce = 1; l_addr = 13'd5; step("R2");
    r_ce = 1; r_addr = 13'd5; r_we = 1; step("R2");
    // R5: busy input level ignored in master mode
    r_bi = 1'b1; l_bi = 1'b0; l_we = 1; step("R5");
    // R8: both move together to a new matching address, owner kept
    l_addr = 13'd9; r_addr = 13'd9; step("R8");
    r_we = 0; l_we = 0; step("R8");
    // R9: collision ends, busy released, nothing reissued
    r_ce = 0; step("R9");
    r_ce = 1; r_addr = 13'd2; step("R9");
    idle();

    // R2: right first, left later
    r_ce = 1; r_addr = 13'h155; step("R2");
    l_ce = 1; l_addr = 13'h155; l_we = 1; step("R2");
    idle();

    // R3: simultaneous arrival
    l_ce = 1; r_ce = 1; l_addr = 13'd33; r_addr = 13'd33; l_we = 1; r_we = 1; step("R3");
    idle();

    // R4: direction does not matter (left read first, right read later)
    l_ce = 1; l_addr = 13'd40; step("R4");
    r_ce = 1; r_addr = 13'd40; step("R4");
    idle();
    l_ce = 1; l_we = 1; l_addr = 13'd40; step("R4");
    r_ce = 1; r_addr = 13'd40; step("R4");
    idle();

    // R1: both enabled, different addresses
    l_ce = 1; r_ce = 1; l_addr = 13'd1; r_addr = 13'd2; l_we = 1; r_we = 1; step("R1");
    idle();

    // R7: addresses differ only in bit 12
    l_ce = 1; r_ce = 1; l_addr = 13'h1003; r_addr = 13'h0003; r_we = 1; step("R7");
    idle();

    // R6: slave mode, busy inputs gate writes only
    master = 0; l_ce = 1; r_ce = 1; l_addr = 13'd8; r_addr = 13'd8;
    l_we = 1; r_we = 1; l_bi = 0; r_bi = 1; step("R6");
    l_bi = 1; r_bi = 0; step("R6");
    idle();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      master = ($urandom % 10) != 0;
      l_ce = ($urandom % 10) < 7;
      r_ce = ($urandom % 10) < 7;
      l_we = $urandom % 2;
      r_we = $urandom % 2;
      l_bi = ($urandom % 4) != 0;
      r_bi = ($urandom % 4) != 0;
      if (($urandom % 3) == 0) l_addr = {1'($urandom % 2), 10'd0, 2'($urandom % 4)};
      if (($urandom % 3) == 0) r_addr = {1'($urandom % 2), 10'd0, 2'($urandom % 4)};
      step("rand R1 R2 R3 R4 R5 R6 R7 R8 R9");
    end

    finish_run();
  end
endmodule